// File: doc/BRIEF.md
# SPI FIFO Interrupt Controller

This block holds the transmit and receive byte queues of a serial peripheral controller and the interrupt logic that watches them. Software (through a small register port) writes bytes for transmission and collects received bytes; the shift engine on the other side drains the transmit queue, fills the receive queue and pulses a completion signal when a transfer ends. The queue depth is a parameter, 64 or 128 entries.

Four interrupt sources are latched: receive data at or above a programmable watermark, transmit data at or below a programmable watermark, a receive byte lost because the queue was full, and transfer completion. Each latched bit is cleared by writing a one to it. A single interrupt line is raised while any latched source is also enabled, so software services a source and then clears it.

The byte paths use valid/ready handshakes. A byte moves on a rising edge where valid and ready are both high. The host transmit push is held off while the transmit queue is full. The host receive pop and the engine transmit pop only see valid while data is present. The engine receive push has no ready: the engine cannot be stalled, so a byte offered to a full receive queue is discarded and flagged.

Top module: `spi_fifo_irq`

## Requirements
- R1: While reset is applied, both queue levels, all latched status bits, all enables and both watermarks are zero. `irq` and `host_rx_valid` are low, and `host_tx_ready` is high.
- R2: Bytes accepted on the host transmit port leave on the engine transmit port in the same order. `host_tx_ready` is low while the transmit queue holds DEPTH bytes, and an offer made then is not stored.
- R3: Bytes pushed by the engine into the receive queue leave on the host receive port in the same order. `host_rx_valid` is high exactly while the receive queue is non-empty.
- R4: An engine receive push while the receive queue holds DEPTH bytes is discarded: the level stays DEPTH and the byte never appears at the host port. The push sets status bit 8 (receive overflow).
- R5: Status bit 0 (receive ready) sets one cycle after the receive level is at or above the receive watermark, which is held in queue-control bits [7:0].
- R6: Status bit 4 (transmit request) sets one cycle after the transmit level is at or below the transmit watermark, which is held in queue-control bits [23:16].
- R7: A one-cycle pulse on `eng_done` sets status bit 12 (transfer complete).
- R8: Writing the status register clears each bit written as 1 and leaves each bit written as 0. Writing all ones clears every source. If a source's set condition is present in the same cycle as its clear, the bit stays set.
- R9: Status bits latch whatever the enable register holds. The enable register (address 0) uses the same bit positions 0, 4, 8 and 12. `irq` is high exactly while some status bit and its enable are both 1.
- R10: A queue-control write with bit 15 set empties the receive queue, and one with bit 31 set empties the transmit queue. Each leaves the other queue untouched. Both bits read back as 0. A push in the same cycle as the emptying of its queue is discarded.
- R11: The queue-status register (address 3) reports the receive level in bits [CW-1:0] and the transmit level in bits [16+CW-1:16], where CW = log2(DEPTH)+1.
- R12: The register map is as follows: address 0 holds the enables, 1 the status, 2 the queue control, and 3 the queue status. Reads are combinational from `reg_addr`, and unassigned bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| host_tx_valid | input | 1 | Host offers a transmit byte |
| host_tx_ready | output | 1 | Transmit queue can accept |
| host_tx_data | input | 8 | Transmit byte from host |
| host_rx_valid | output | 1 | Receive byte available |
| host_rx_ready | input | 1 | Host takes the receive byte |
| host_rx_data | output | 8 | Oldest receive byte |
| eng_tx_valid | output | 1 | Transmit byte available to engine |
| eng_tx_ready | input | 1 | Engine takes the transmit byte |
| eng_tx_data | output | 8 | Oldest transmit byte |
| eng_rx_valid | input | 1 | Engine pushes a received byte |
| eng_rx_data | input | 8 | Received byte from engine |
| eng_done | input | 1 | Transfer-complete pulse |
| irq | output | 1 | Combined interrupt |

## Verification
Two pairs of functions can land on the same clock edge. The first is a write-one-to-clear of the completion bit together with an `eng_done` pulse. The bench drives both in a single cycle and expects the bit to read as set afterwards, because setting takes precedence. The second is a queue-emptying control write together with an engine receive push. The bench drives these in one cycle and expects the receive level to read zero, so the byte is gone.

// File: rtl/sfi_pkg.sv
package sfi_pkg;

  localparam int REG_AW     = 2;
  localparam int DATA_W     = 8;
  localparam int TRIG_W     = 8;
  localparam int NSRC       = 4;
  localparam int SRC_STRIDE = 4;

  // Source index order fixes the status bit position: index * SRC_STRIDE
  localparam int SRC_RXRDY = 0;
  localparam int SRC_TXREQ = 1;
  localparam int SRC_RXOVF = 2;
  localparam int SRC_DONE  = 3;

  localparam int RX_TRIG_LSB = 0;
  localparam int TX_TRIG_LSB = 16;
  localparam int RX_RST_BIT  = 15;
  localparam int TX_RST_BIT  = 31;
  localparam int RX_CNT_LSB  = 0;
  localparam int TX_CNT_LSB  = 16;

  typedef enum logic [REG_AW-1:0] {
    A_IEN   = 2'd0,
    A_ISTAT = 2'd1,
    A_FCTL  = 2'd2,
    A_FSTAT = 2'd3
  } sfi_addr_e;

  function automatic logic [NSRC-1:0] gather_src(input logic [31:0] w);
    logic [NSRC-1:0] g;
    for (int i = 0; i < NSRC; i++) g[i] = w[SRC_STRIDE*i];
    return g;
  endfunction

  function automatic logic [31:0] spread_src(input logic [NSRC-1:0] v);
    logic [31:0] s;
    s = '0;
    for (int i = 0; i < NSRC; i++) s[SRC_STRIDE*i] = v[i];
    return s;
  endfunction

endpackage

// File: rtl/sfi_byte_fifo.sv
module sfi_byte_fifo #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = PW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic [CW-1:0] level
);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  assign in_ready  = (level != CW'(DEPTH));
  assign out_valid = (level != '0);
  assign out_data  = mem[rd_ptr];
  assign do_push   = in_valid && in_ready && !flush;
  assign do_pop    = out_valid && out_ready && !flush;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

endmodule

// File: rtl/sfi_irq_bank.sv
module sfi_irq_bank #(
  parameter int NS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NS-1:0] set_vec,
  input  logic [NS-1:0] clr_vec,
  input  logic [NS-1:0] en_vec,
  output logic [NS-1:0] stat,
  output logic          irq
);

  for (genvar i = 0; i < NS; i++) begin : g_src
    // Set takes precedence over a same-cycle clear
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat[i] <= 1'b0;
      else        stat[i] <= set_vec[i] | (stat[i] & ~clr_vec[i]);
    end
  end

  assign irq = |(stat & en_vec);

endmodule

// File: rtl/sfi_cfg_regs.sv
module sfi_cfg_regs
  import sfi_pkg::*;
#(
  parameter int CW = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [REG_AW-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic [NSRC-1:0]   stat,
  input  logic [CW-1:0]     rx_level,
  input  logic [CW-1:0]     tx_level,
  output logic [31:0]       rdata,
  output logic [TRIG_W-1:0] rx_trig,
  output logic [TRIG_W-1:0] tx_trig,
  output logic [NSRC-1:0]   irq_en,
  output logic              rx_flush,
  output logic              tx_flush,
  output logic [NSRC-1:0]   stat_clr
);

  sfi_addr_e sel;
  logic      wr_ctl;

  assign sel      = sfi_addr_e'(addr);
  assign wr_ctl   = wr && (sel == A_FCTL);
  assign rx_flush = wr_ctl && wdata[RX_RST_BIT];
  assign tx_flush = wr_ctl && wdata[TX_RST_BIT];
  assign stat_clr = (wr && sel == A_ISTAT) ? gather_src(wdata) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_trig <= '0;
      tx_trig <= '0;
      irq_en  <= '0;
    end else if (wr) begin
      if (sel == A_IEN) irq_en <= gather_src(wdata);
      if (sel == A_FCTL) begin
        rx_trig <= wdata[RX_TRIG_LSB +: TRIG_W];
        tx_trig <= wdata[TX_TRIG_LSB +: TRIG_W];
      end
    end
  end

  always_comb begin
    rdata = '0;
    case (sel)
      A_IEN:   rdata = spread_src(irq_en);
      A_ISTAT: rdata = spread_src(stat);
      A_FCTL: begin
        rdata[RX_TRIG_LSB +: TRIG_W] = rx_trig;
        rdata[TX_TRIG_LSB +: TRIG_W] = tx_trig;
      end
      A_FSTAT: begin
        rdata[RX_CNT_LSB +: CW] = rx_level;
        rdata[TX_CNT_LSB +: CW] = tx_level;
      end
      default: rdata = '0;
    endcase
  end

endmodule

// File: rtl/spi_fifo_irq.sv
module spi_fifo_irq
  import sfi_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              host_tx_valid,
  output logic              host_tx_ready,
  input  logic [DATA_W-1:0] host_tx_data,
  output logic              host_rx_valid,
  input  logic              host_rx_ready,
  output logic [DATA_W-1:0] host_rx_data,
  output logic              eng_tx_valid,
  input  logic              eng_tx_ready,
  output logic [DATA_W-1:0] eng_tx_data,
  input  logic              eng_rx_valid,
  input  logic [DATA_W-1:0] eng_rx_data,
  input  logic              eng_done,
  output logic              irq
);

  logic [CW-1:0]     rx_level, tx_level;
  logic [TRIG_W-1:0] rx_trig, tx_trig;
  logic [NSRC-1:0]   irq_en, stat, stat_clr, stat_set;
  logic              rx_flush, tx_flush, rx_in_ready;

  sfi_cfg_regs #(.CW(CW)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (reg_wr),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .stat     (stat),
    .rx_level (rx_level),
    .tx_level (tx_level),
    .rdata    (reg_rdata),
    .rx_trig  (rx_trig),
    .tx_trig  (tx_trig),
    .irq_en   (irq_en),
    .rx_flush (rx_flush),
    .tx_flush (tx_flush),
    .stat_clr (stat_clr)
  );

  sfi_byte_fifo #(.DEPTH(DEPTH), .DW(DATA_W)) u_txq (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (tx_flush),
    .in_valid  (host_tx_valid),
    .in_ready  (host_tx_ready),
    .in_data   (host_tx_data),
    .out_valid (eng_tx_valid),
    .out_ready (eng_tx_ready),
    .out_data  (eng_tx_data),
    .level     (tx_level)
  );

  sfi_byte_fifo #(.DEPTH(DEPTH), .DW(DATA_W)) u_rxq (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (rx_flush),
    .in_valid  (eng_rx_valid),
    .in_ready  (rx_in_ready),
    .in_data   (eng_rx_data),
    .out_valid (host_rx_valid),
    .out_ready (host_rx_ready),
    .out_data  (host_rx_data),
    .level     (rx_level)
  );

  always_comb begin
    stat_set            = '0;
    stat_set[SRC_RXRDY] = (32'(rx_level) >= 32'(rx_trig));
    stat_set[SRC_TXREQ] = (32'(tx_level) <= 32'(tx_trig));
    stat_set[SRC_RXOVF] = eng_rx_valid && !rx_in_ready;
    stat_set[SRC_DONE]  = eng_done;
  end

  sfi_irq_bank #(.NS(NSRC)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (stat_set),
    .clr_vec (stat_clr),
    .en_vec  (irq_en),
    .stat    (stat),
    .irq     (irq)
  );

endmodule

// File: rtl/sfi_checker.sv
module sfi_checker
  import sfi_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [REG_AW-1:0] reg_addr,
  input logic [31:0]       reg_wdata,
  input logic              eng_rx_valid,
  input logic              eng_done,
  input logic              host_tx_ready,
  input logic              irq,
  input logic [CW-1:0]     rx_level,
  input logic [CW-1:0]     tx_level,
  input logic [NSRC-1:0]   stat,
  input logic [NSRC-1:0]   irq_en
);

  a_r4_overflow_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_rx_valid && rx_level == CW'(DEPTH)) |=> stat[SRC_RXOVF]);

  a_r7_done_latch: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |=> stat[SRC_DONE]);

  a_r8_clear_done: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_ISTAT && reg_wdata[SRC_STRIDE*SRC_DONE] && !eng_done)
      |=> !stat[SRC_DONE]);

  a_r10_rx_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_FCTL && reg_wdata[RX_RST_BIT]) |=> (rx_level == '0));

  a_r10_tx_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_FCTL && reg_wdata[TX_RST_BIT]) |=> (tx_level == '0));

  a_r2_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level <= CW'(DEPTH)) && (rx_level <= CW'(DEPTH)));

  a_r2_full_holds_off: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level == CW'(DEPTH)) |-> !host_tx_ready);

  a_r9_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en == '0) |-> !irq);

endmodule

bind spi_fifo_irq sfi_checker #(.DEPTH(DEPTH)) u_sfi_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .reg_wr        (reg_wr),
  .reg_addr      (reg_addr),
  .reg_wdata     (reg_wdata),
  .eng_rx_valid  (eng_rx_valid),
  .eng_done      (eng_done),
  .host_tx_ready (host_tx_ready),
  .irq           (irq),
  .rx_level      (rx_level),
  .tx_level      (tx_level),
  .stat          (stat),
  .irq_en        (irq_en)
);

// File: tb/spi_fifo_irq_tb.sv
module spi_fifo_irq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 64;
  localparam int CW         = $clog2(DEPTH) + 1;
  localparam int WDOG       = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        host_tx_valid = 1'b0;
  logic        host_tx_ready;
  logic [7:0]  host_tx_data = '0;
  logic        host_rx_valid;
  logic        host_rx_ready = 1'b0;
  logic [7:0]  host_rx_data;
  logic        eng_tx_valid;
  logic        eng_tx_ready = 1'b0;
  logic [7:0]  eng_tx_data;
  logic        eng_rx_valid = 1'b0;
  logic [7:0]  eng_rx_data = '0;
  logic        eng_done = 1'b0;
  logic        irq;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_fifo_irq #(.DEPTH(DEPTH)) u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_wr        (reg_wr),
    .reg_addr      (reg_addr),
    .reg_wdata     (reg_wdata),
    .reg_rdata     (reg_rdata),
    .host_tx_valid (host_tx_valid),
    .host_tx_ready (host_tx_ready),
    .host_tx_data  (host_tx_data),
    .host_rx_valid (host_rx_valid),
    .host_rx_ready (host_rx_ready),
    .host_rx_data  (host_rx_data),
    .eng_tx_valid  (eng_tx_valid),
    .eng_tx_ready  (eng_tx_ready),
    .eng_tx_data   (eng_tx_data),
    .eng_rx_valid  (eng_rx_valid),
    .eng_rx_data   (eng_rx_data),
    .eng_done      (eng_done),
    .irq           (irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic host_push(input logic [7:0] b);
    @(negedge clk);
    host_tx_valid = 1'b1; host_tx_data = b;
    @(negedge clk);
    host_tx_valid = 1'b0;
  endtask

  task automatic eng_push(input logic [7:0] b);
    @(negedge clk);
    eng_rx_valid = 1'b1; eng_rx_data = b;
    @(negedge clk);
    eng_rx_valid = 1'b0;
  endtask

  task automatic eng_pop(output logic [7:0] b, output logic v);
    @(negedge clk);
    v = eng_tx_valid; b = eng_tx_data; eng_tx_ready = 1'b1;
    @(negedge clk);
    eng_tx_ready = 1'b0;
  endtask

  task automatic host_pop(output logic [7:0] b, output logic v);
    @(negedge clk);
    v = host_rx_valid; b = host_rx_data; host_rx_ready = 1'b1;
    @(negedge clk);
    host_rx_ready = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk);
    eng_done = 1'b1;
    @(negedge clk);
    eng_done = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] r;
    rd_reg(2'd0, r); chk("R1 enables", r, 32'h0);
    rd_reg(2'd1, r); chk("R1 status", r, 32'h0);
    rd_reg(2'd2, r); chk("R1 watermarks", r, 32'h0);
    rd_reg(2'd3, r); chk("R1 levels", r, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 host_rx_valid", {31'b0, host_rx_valid}, 32'h0);
    chk("R1 host_tx_ready", {31'b0, host_tx_ready}, 32'h1);
  endtask

  task automatic t_tx_path();
    logic [31:0] r; logic [7:0] b; logic v;
    host_push(8'hA1); host_push(8'hA2); host_push(8'hA3);
    rd_reg(2'd3, r);
    chk("R11 tx level field", {16'b0, r[31:16]}, 32'd3);
    chk("R11 rx level field", {16'b0, r[15:0]}, 32'd0);
    for (int i = 0; i < 3; i++) begin
      eng_pop(b, v);
      chk("R2 tx valid", {31'b0, v}, 32'h1);
      chk("R2 tx order", {24'b0, b}, 32'hA1 + i);
    end
    for (int i = 0; i < DEPTH; i++) host_push(8'(i));
    chk("R2 full holds off", {31'b0, host_tx_ready}, 32'h0);
    host_push(8'hEE);
    rd_reg(2'd3, r);
    chk("R2 full level", {25'b0, r[16 +: CW]}, DEPTH);
    eng_pop(b, v);
    chk("R2 head after full", {24'b0, b}, 32'h00);
    eng_push(8'h55);
    wr_reg(2'd2, 32'h8000_0000);
    rd_reg(2'd3, r);
    chk("R10 tx emptied", {25'b0, r[16 +: CW]}, 32'd0);
    chk("R10 rx untouched", {25'b0, r[0 +: CW]}, 32'd1);
    wr_reg(2'd2, 32'h0000_8000);
  endtask

  task automatic t_rx_path();
    logic [7:0] b; logic v;
    for (int i = 0; i < 4; i++) eng_push(8'h30 + 8'(i));
    chk("R3 rx valid", {31'b0, host_rx_valid}, 32'h1);
    for (int i = 0; i < 4; i++) begin
      host_pop(b, v);
      chk("R3 rx order", {24'b0, b}, 32'h30 + i);
    end
    chk("R3 rx empty", {31'b0, host_rx_valid}, 32'h0);
  endtask

  task automatic t_overflow();
    logic [31:0] r; logic [7:0] b; logic v;
    wr_reg(2'd1, 32'hFFFF_FFFF);
    for (int i = 0; i < DEPTH; i++) eng_push(8'(i + 1));
    rd_reg(2'd1, r);
    chk("R4 no overflow yet", {31'b0, r[8]}, 32'h0);
    eng_push(8'hFE);
    rd_reg(2'd1, r);
    chk("R4 overflow flag", {31'b0, r[8]}, 32'h1);
    rd_reg(2'd3, r);
    chk("R4 level stays full", {25'b0, r[0 +: CW]}, DEPTH);
    for (int i = 0; i < DEPTH; i++) host_pop(b, v);
    chk("R4 last kept byte", {24'b0, b}, DEPTH);
    chk("R4 dropped byte absent", {31'b0, host_rx_valid}, 32'h0);
    wr_reg(2'd1, 32'h0000_0100);
    rd_reg(2'd1, r);
    chk("R8 overflow cleared", {31'b0, r[8]}, 32'h0);
  endtask

  task automatic t_watermarks();
    logic [31:0] r; logic [7:0] b; logic v;
    wr_reg(2'd2, 32'h8002_8003);
    for (int i = 0; i < 3; i++) host_push(8'h70 + 8'(i));
    eng_push(8'h01); eng_push(8'h02);
    idle(2);
    wr_reg(2'd1, 32'hFFFF_FFFF);
    idle(2);
    rd_reg(2'd1, r);
    chk("R5 below rx mark", {31'b0, r[0]}, 32'h0);
    chk("R6 above tx mark", {31'b0, r[4]}, 32'h0);
    chk("R8 all-ones clears", r, 32'h0);
    eng_push(8'h03);
    idle(2);
    rd_reg(2'd1, r);
    chk("R5 rx at mark", {31'b0, r[0]}, 32'h1);
    eng_pop(b, v);
    idle(2);
    rd_reg(2'd1, r);
    chk("R6 tx at mark", {31'b0, r[4]}, 32'h1);
    wr_reg(2'd2, 32'h8000_8000);
  endtask

  task automatic t_done_w1c();
    logic [31:0] r;
    wr_reg(2'd1, 32'h0000_1000);
    pulse_done();
    rd_reg(2'd1, r);
    chk("R7 done latched", {31'b0, r[12]}, 32'h1);
    wr_reg(2'd1, 32'h0000_0000);
    rd_reg(2'd1, r);
    chk("R8 zero write keeps", {31'b0, r[12]}, 32'h1);
    wr_reg(2'd1, 32'h0000_1000);
    rd_reg(2'd1, r);
    chk("R8 one write clears", {31'b0, r[12]}, 32'h0);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 32'h0000_1000; eng_done = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0; eng_done = 1'b0;
    rd_reg(2'd1, r);
    chk("R8 set beats clear", {31'b0, r[12]}, 32'h1);
    wr_reg(2'd1, 32'h0000_1000);
  endtask

  task automatic t_irq();
    logic [31:0] r;
    pulse_done();
    rd_reg(2'd1, r);
    chk("R9 latched while masked", {31'b0, r[12]}, 32'h1);
    chk("R9 masked irq low", {31'b0, irq}, 32'h0);
    wr_reg(2'd0, 32'hFFFF_FFFF);
    rd_reg(2'd0, r);
    chk("R12 enable layout", r, 32'h0000_1111);
    wr_reg(2'd0, 32'h0000_0100);
    chk("R9 other enable irq low", {31'b0, irq}, 32'h0);
    wr_reg(2'd0, 32'h0000_1000);
    chk("R9 enabled irq high", {31'b0, irq}, 32'h1);
    wr_reg(2'd1, 32'h0000_1000);
    chk("R9 irq after clear", {31'b0, irq}, 32'h0);
    wr_reg(2'd0, 32'h0);
  endtask

  task automatic t_flush();
    logic [31:0] r;
    eng_push(8'h11); eng_push(8'h12);
    host_push(8'h21); host_push(8'h22);
    wr_reg(2'd2, 32'h0000_8000);
    rd_reg(2'd3, r);
    chk("R10 rx emptied", {25'b0, r[0 +: CW]}, 32'd0);
    chk("R10 tx kept", {25'b0, r[16 +: CW]}, 32'd2);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = 32'h0000_8000;
    eng_rx_valid = 1'b1; eng_rx_data = 8'h99;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0; eng_rx_valid = 1'b0;
    rd_reg(2'd3, r);
    chk("R10 push during empty dropped", {25'b0, r[0 +: CW]}, 32'd0);
    wr_reg(2'd2, 32'hFFFF_FFFF);
    rd_reg(2'd2, r);
    chk("R12 control readback", r, 32'h00FF_00FF);
    rd_reg(2'd3, r);
    chk("R10 both emptied", r, 32'h0);
    wr_reg(2'd2, 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 2);
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    idle(2);
    t_tx_path();
    t_rx_path();
    t_overflow();
    t_watermarks();
    t_done_w1c();
    t_irq();
    t_flush();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule